// File: doc/BRIEF.md
# Edge Timestamp Timer Pair

The block timestamps the rising edge of a slow external pulse, such as a once-per-second marker, without needing software to respond quickly. A free-running reference counter advances once every `DIV` clocks (four by default, so a 33.333 MHz clock gives one count about every 120 ns). A second counter, the elapsed counter, returns to zero on each rising edge of the synchronized pulse and then counts up at the same rate. Software may poll at any later time. Subtracting the elapsed count from the reference count, modulo 2^`CNT_W`, recovers the reference value at the edge to within one count. Poll latency therefore does not affect the result.

A read strobe copies the synchronized level, both counters and the overflow flag into snapshot registers in one clock, so a read returns a coherent set. The stored level is the one the elapsed counter already reflects, so a new level is never paired with an elapsed value from before the edge. A small tracker state machine (states `TRK_LOW`, `TRK_HIGH`) follows the level seen at strobes. On a strobe that sees the level high while the tracker is low (transition `TRK_LOW -> TRK_HIGH`), the block computes the corrected timestamp and marks it fresh. On a strobe that sees the level low while the tracker is high (transition `TRK_HIGH -> TRK_LOW`), only the tracker changes. The elapsed counter has its own machine. `EL_IDLE` holds zero from reset until the first edge. `EL_RUN` counts. `EL_SAT` holds the maximum and shows overflow. Any rising edge moves the counter from any of these states to `EL_RUN` with the count at zero. When a count tick arrives at the maximum, `EL_RUN` moves to `EL_SAT`.

Top module: `edge_stamp_timer`

## Requirements
- R1: The reference counter increases by one every `DIV` clocks and wraps from 2^`CNT_W`-1 to 0. Two strobes taken k·`DIV` clocks apart return reference values that differ by k.
- R2: `pulse_in` passes through `SYNC_STAGES` (2) flops. A rising edge on the synchronized level clears the elapsed counter and the overflow flag. The cleared count is in place three clocks after `pulse_in` rises when `pulse_in` is driven away from the clock edge. A strobe one clock later sees the elapsed count at 0 or 1.
- R3: After an edge the elapsed counter increases by one on each reference tick. From reset until the first edge it stays at zero.
- R4: The elapsed counter saturates at 2^`CNT_W`-1 when a tick arrives at that value. The overflow flag is then set and stays set until the next rising edge clears both.
- R5: A clock with `rd_stb` high captures level, reference, elapsed and overflow together. Snapshot contents do not change on clocks without `rd_stb`.
- R6: The captured level is the one the elapsed counter already reflects. A strobe in the clock where the edge is only being detected returns level 0 with the elapsed count from before the edge.
- R7: A strobe that sees level 1 while the tracker is low stores stamp = reference − elapsed (mod 2^`CNT_W`) and sets the fresh bit. A further strobe with level still 1 clears the fresh bit and keeps the stamp.
- R8: A strobe that sees level 0 produces no stamp. The fresh bit reads 0, the stored stamp is unchanged, and the tracker returns to low.
- R9: After reset every readable field is zero.
- R10: `rd_sel` picks the field driven on `rd_data`: 0 status (bit 0 level, bit 1 overflow, bit 2 fresh, other bits zero), 1 reference, 2 elapsed, 3 stamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters run from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | External pulse, asynchronous to `clk` |
| rd_stb | input | 1 | Snapshot strobe, one clock wide per capture |
| rd_sel | input | 2 | Field select for `rd_data` |
| rd_data | output | CNT_W | Selected snapshot field |

## Verification
A wrong count or state inside the block shows up at the ports only through a snapshot, so it appears on `rd_data` one clock after the next strobe. The bench model tracks every cycle and strobes often, so a prescaler phase error shows up as a reference value off by one within a few strobes. A tracker stuck in one state shows up as a wrong fresh bit on the first strobe after a level change. An elapsed machine that wraps instead of saturating shows a small count with the overflow bit clear on the strobe after saturation.

// File: rtl/est_pkg.sv
package est_pkg;

    typedef enum logic [1:0] {
        EL_IDLE = 2'd0,
        EL_RUN  = 2'd1,
        EL_SAT  = 2'd2
    } el_state_t;

    typedef enum logic {
        TRK_LOW  = 1'b0,
        TRK_HIGH = 1'b1
    } trk_state_t;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_REF     = 2'd1,
        SEL_ELAPSED = 2'd2,
        SEL_STAMP   = 2'd3
    } rd_sel_t;

endpackage

// File: rtl/est_sync.sv
module est_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl_q,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    // prev is the level the elapsed counter has already acted on
    assign lvl_q = prev;
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/est_refcnt.sv
module est_refcnt #(
    parameter int CNT_W = 16,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             tick,
    output logic [CNT_W-1:0] ref_cnt
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

    logic [PW-1:0] pre;

    assign tick = (pre == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre     <= '0;
            ref_cnt <= '0;
        end else begin
            pre <= tick ? '0 : pre + 1'b1;
            if (tick) ref_cnt <= ref_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/est_elapsed.sv
module est_elapsed
    import est_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise,
    output logic [CNT_W-1:0] elap_cnt,
    output logic             elap_ovf
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    el_state_t state, state_n;
    logic      at_max;

    assign at_max = (elap_cnt == MAXV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EL_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            EL_IDLE: if (rise) state_n = EL_RUN;
            EL_RUN: begin
                if (rise)                  state_n = EL_RUN;
                else if (tick && at_max)   state_n = EL_SAT;
            end
            EL_SAT:  if (rise) state_n = EL_RUN;
            default: state_n = EL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elap_cnt <= '0;
        end else if (rise) begin
            elap_cnt <= '0;
        end else if (state == EL_RUN && tick && !at_max) begin
            elap_cnt <= elap_cnt + 1'b1;
        end
    end

    assign elap_ovf = (state == EL_SAT);
endmodule

// File: rtl/est_snapshot.sv
module est_snapshot
    import est_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             lvl,
    input  logic [CNT_W-1:0] ref_cnt,
    input  logic [CNT_W-1:0] elap_cnt,
    input  logic             elap_ovf,
    output logic             snap_lvl,
    output logic             snap_ovf,
    output logic             snap_fresh,
    output logic [CNT_W-1:0] snap_ref,
    output logic [CNT_W-1:0] snap_elap,
    output logic [CNT_W-1:0] snap_stamp
);
    trk_state_t trk, trk_n;
    logic       take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk <= TRK_LOW;
        else        trk <= trk_n;
    end

    always_comb begin
        trk_n = trk;
        unique case (trk)
            TRK_LOW:  if (rd_stb && lvl)  trk_n = TRK_HIGH;
            TRK_HIGH: if (rd_stb && !lvl) trk_n = TRK_LOW;
            default:  trk_n = TRK_LOW;
        endcase
    end

    assign take = rd_stb && (trk == TRK_LOW) && lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_lvl   <= 1'b0;
            snap_ovf   <= 1'b0;
            snap_fresh <= 1'b0;
            snap_ref   <= '0;
            snap_elap  <= '0;
            snap_stamp <= '0;
        end else if (rd_stb) begin
            snap_lvl   <= lvl;
            snap_ovf   <= elap_ovf;
            snap_ref   <= ref_cnt;
            snap_elap  <= elap_cnt;
            snap_fresh <= take;
            if (take) snap_stamp <= ref_cnt - elap_cnt;
        end
    end
endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer
    import est_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             rd_stb,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data
);
    logic             lvl_q, rise, tick;
    logic [CNT_W-1:0] ref_cnt, elap_cnt;
    logic             elap_ovf;
    logic             snap_lvl, snap_ovf, snap_fresh;
    logic [CNT_W-1:0] snap_ref, snap_elap, snap_stamp;

    est_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pulse_in),
        .lvl_q(lvl_q), .rise(rise)
    );

    est_refcnt #(.CNT_W(CNT_W), .DIV(DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ref_cnt(ref_cnt)
    );

    est_elapsed #(.CNT_W(CNT_W)) u_elap (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rise(rise),
        .elap_cnt(elap_cnt), .elap_ovf(elap_ovf)
    );

    est_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .lvl(lvl_q),
        .ref_cnt(ref_cnt), .elap_cnt(elap_cnt), .elap_ovf(elap_ovf),
        .snap_lvl(snap_lvl), .snap_ovf(snap_ovf), .snap_fresh(snap_fresh),
        .snap_ref(snap_ref), .snap_elap(snap_elap), .snap_stamp(snap_stamp)
    );

    always_comb begin
        unique case (rd_sel_t'(rd_sel))
            SEL_STATUS:  rd_data = CNT_W'({snap_fresh, snap_ovf, snap_lvl});
            SEL_REF:     rd_data = snap_ref;
            SEL_ELAPSED: rd_data = snap_elap;
            SEL_STAMP:   rd_data = snap_stamp;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/est_checker.sv
module est_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             rd_stb,
    input logic             lvl_q,
    input logic [CNT_W-1:0] ref_cnt,
    input logic [CNT_W-1:0] elap_cnt,
    input logic             elap_ovf,
    input logic             snap_fresh,
    input logic [CNT_W-1:0] snap_ref,
    input logic [CNT_W-1:0] snap_elap,
    input logic [CNT_W-1:0] snap_stamp
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    // R1
    ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cnt != $past(ref_cnt)) |-> (ref_cnt == CNT_W'($past(ref_cnt) + 1'b1)));

    // R2
    rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (elap_cnt == '0 && !elap_ovf));

    // R3
    elap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> (CNT_W'(elap_cnt - $past(elap_cnt)) <= CNT_W'(1)));

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elap_ovf && !rise) |=> (elap_ovf && elap_cnt == MAXV));

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ($stable(snap_ref) && $stable(snap_elap) && $stable(snap_stamp)));

    // R7
    stamp_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_fresh |-> (snap_stamp == CNT_W'(snap_ref - snap_elap)));

    // R8
    fall_no_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !lvl_q) |=> (!snap_fresh && $stable(snap_stamp)));
endmodule

bind edge_stamp_timer est_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rise(rise), .rd_stb(rd_stb), .lvl_q(lvl_q),
    .ref_cnt(ref_cnt), .elap_cnt(elap_cnt), .elap_ovf(elap_ovf),
    .snap_fresh(snap_fresh), .snap_ref(snap_ref), .snap_elap(snap_elap),
    .snap_stamp(snap_stamp)
);

// File: tb/test_edge_stamp_timer.sv
module test_edge_stamp_timer;
    localparam int CNT_W = 10;
    localparam int DIV   = 4;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_in = 1'b0;
    logic             rd_stb = 1'b0;
    logic [1:0]       rd_sel = 2'd0;
    logic [CNT_W-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_stamp_timer #(.CNT_W(CNT_W), .DIV(DIV), .SYNC_STAGES(2)) i_edge_stamp_timer (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
        .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // behavioural model state
    int m_s1, m_s2, m_s3, m_pre, m_ref, m_el, m_st;
    int m_lvl, m_sref, m_sel, m_sovf, m_trk, m_stamp, m_fresh;
    int t_rise, t_tick, o_ref, o_el, o_st, o_s3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_ref = 0; m_el = 0; m_st = 0;
            m_lvl = 0; m_sref = 0; m_sel = 0; m_sovf = 0; m_trk = 0; m_stamp = 0; m_fresh = 0;
        end else begin
            t_rise = (m_s2 == 1 && m_s3 == 0);
            t_tick = (m_pre == DIV - 1);
            o_ref = m_ref; o_el = m_el; o_st = m_st; o_s3 = m_s3;
            if (t_rise) begin
                m_el = 0; m_st = 1;
            end else if (m_st == 1 && t_tick) begin
                if (m_el == MAXV) m_st = 2;
                else m_el = m_el + 1;
            end
            if (t_tick) m_ref = (m_ref + 1) & MAXV;
            m_pre = t_tick ? 0 : m_pre + 1;
            if (rd_stb) begin
                m_lvl = o_s3; m_sref = o_ref; m_sel = o_el; m_sovf = (o_st == 2);
                if (m_trk == 0 && o_s3 == 1) begin
                    m_stamp = (o_ref - o_el) & MAXV; m_fresh = 1; m_trk = 1;
                end else begin
                    m_fresh = 0;
                    if (m_trk == 1 && o_s3 == 0) m_trk = 0;
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pulse_in;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            case (rd_sel)
                2'd0: chk("R10 status vs model", int'(rd_data), m_fresh * 4 + m_sovf * 2 + m_lvl);
                2'd1: chk("R5 reference vs model", int'(rd_data), m_sref);
                2'd2: chk("R5 elapsed vs model", int'(rd_data), m_sel);
                default: chk("R7 stamp vs model", int'(rd_data), m_stamp);
            endcase
        end
    end

    // call at a negedge; capture happens at the following posedge
    task automatic strobe();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic rd(input int sel, output int val);
        rd_sel = 2'(sel);
        #1;
        val = int'(rd_data);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int v, a, b, e1, e2, st_keep;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            rd(s, v);
            chk("R9 reset field", v, 0);
        end
        rst_n = 1'b1;

        // no edge yet: elapsed idle at zero, status clear
        repeat (10) @(negedge clk);
        strobe();
        rd(2, v); chk("R3 elapsed idle before first edge", v, 0);
        rd(0, v); chk("R10 status before edge", v, 0);
        rd(1, a);

        // reference rate
        repeat (DIV * 7 - 1) @(negedge clk);
        strobe();
        rd(1, b);
        chk("R1 reference advance over 7 ticks", (b - a) & MAXV, 7);

        // rising edge timing and coherence
        pulse_in = 1'b1;
        repeat (2) @(negedge clk);
        strobe();
        rd(0, v); chk("R6 level not yet reflected", v & 1, 0);
        rd(3, v); chk("R6 no stamp while edge pending", v, 0);
        strobe();
        rd(0, v); chk("R10 status level and fresh", v, 5);
        rd(2, e1); chk("R2 elapsed restarted", int'(e1 <= 1), 1);
        rd(1, a);
        rd(3, v); chk("R7 stamp equals ref minus elapsed", v, (a - e1) & MAXV);
        st_keep = v;

        // second strobe while high: no new stamp
        repeat (3) @(negedge clk);
        strobe();
        rd(0, v); chk("R7 fresh cleared on repeat high", (v >> 2) & 1, 0);
        rd(3, v); chk("R7 stamp kept", v, st_keep);
        rd(2, e1);
        repeat (DIV * 5 - 1) @(negedge clk);
        strobe();
        rd(2, e2); chk("R3 elapsed advance over 5 ticks", e2 - e1, 5);

        // falling edge
        pulse_in = 1'b0;
        repeat (5) @(negedge clk);
        strobe();
        rd(0, v); chk("R8 status after fall", v, 0);
        rd(3, v); chk("R8 stamp unchanged on fall", v, st_keep);

        // saturation
        repeat (DIV * (MAXV + 8)) @(negedge clk);
        strobe();
        rd(2, v); chk("R4 elapsed saturated", v, MAXV);
        rd(0, v); chk("R4 overflow flag set", (v >> 1) & 1, 1);
        repeat (DIV * 3) @(negedge clk);
        strobe();
        rd(2, v); chk("R4 elapsed holds at max", v, MAXV);

        // new edge clears overflow and stamps again
        pulse_in = 1'b1;
        repeat (6) @(negedge clk);
        strobe();
        rd(0, v); chk("R4 overflow cleared by edge", v, 5);
        rd(1, a);
        rd(2, e1);
        rd(3, v); chk("R7 fresh stamp after saturation", v, (a - e1) & MAXV);

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule